// File: doc/BRIEF.md
# Bridge Deadlock Resolver

This block sits between the two halves of a processor-to-PCI bridge and watches for a mutual wait. Each half reports what it is doing: a transfer kind, whether its read FIFO is empty, and whether its write FIFO is full. The processor half also reports a split flag, which is high once a read that crosses a 4-byte boundary has already fetched part of its data. A half raises a registered stall flag whenever its current transfer cannot finish without owning the other bus.

When both stall flags are high in the same cycle, a small state machine issues a one-cycle lock pulse. It then always tells the processor half to yield. Reads and non-posted writes on the processor half are ended with a one-cycle retry command, and a retried split read also gets a discard command. A posted write on the processor half is left to finish. The PCI half is never asked to back out.

The controller has four states. `LK_ARMED` waits for both flags to be high, and moves to `LK_LOCK` when they are. `LK_LOCK` drives the lock pulse. From there it moves to `LK_RETRY` for a read or non-posted write, or to `LK_HOLD` for a posted write or an idle processor half. `LK_RETRY` drives retry, and discard when a split read was captured, and always moves to `LK_HOLD`. `LK_HOLD` waits until at least one stall flag is low, and then returns to `LK_ARMED`.

Top module: `bdl_bridge_lock`

## Requirements
- R1: A side's stall flag goes high one clock after that side presents a read (kind code 1) while its read-FIFO-empty input is high.
- R2: A side's stall flag goes high one clock after that side presents a non-posted write (kind code 2), whatever the state of its FIFOs.
- R3: A side's stall flag goes high one clock after that side presents a posted write (kind code 3) while its write-FIFO-full input is high. An idle side (kind code 0), a read with data present, and a posted write with room left all leave the flag low.
- R4: `lock_pulse` is high for exactly one cycle, in the cycle after both stall flags were high together.
- R5: Once it has fired, `lock_pulse` stays low until at least one stall flag has been seen low.
- R6: In the cycle after a lock pulse, `cpu_retry` is high for one cycle if the processor half is doing a read or a non-posted write.
- R7: If the processor half is doing a posted write or is idle at that point, no retry and no discard are issued.
- R8: `cpu_discard` is high, together with the retry, only when the retried transfer is a read and `cpu_split` is high.
- R9: In the cycle after a retry, `cpu_stall` is low whatever the inputs are.
- R10: The resolution never acts on the PCI half. `pci_stall` keeps following its own inputs throughout.
- R11: A synchronous active-high reset clears `cpu_stall`, `pci_stall`, `lock_pulse`, `cpu_retry` and `cpu_discard`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cpu_kind | input | 2 | Processor-half transfer kind: 0 idle, 1 read, 2 non-posted write, 3 posted write |
| cpu_rd_empty | input | 1 | Processor-half read FIFO holds no data |
| cpu_wr_full | input | 1 | Processor-half write FIFO is full |
| cpu_split | input | 1 | Processor-half read has already fetched part of a split transfer |
| pci_kind | input | 2 | PCI-half transfer kind, same encoding as `cpu_kind` |
| pci_rd_empty | input | 1 | PCI-half read FIFO holds no data |
| pci_wr_full | input | 1 | PCI-half write FIFO is full |
| cpu_stall | output | 1 | Registered stall flag of the processor half |
| pci_stall | output | 1 | Registered stall flag of the PCI half |
| lock_pulse | output | 1 | One-cycle bridge-lock indication |
| cpu_retry | output | 1 | One-cycle command to end the processor-half transfer with a retry |
| cpu_discard | output | 1 | With the retry, drop the partially fetched read data |

## Verification
A controller stuck in `LK_HOLD` or `LK_LOCK` shows up at the ports within two cycles of a fresh overlap of stalls: either the lock pulse is missing, or it lasts more than one cycle. A wrong choice of branch out of `LK_LOCK` shows up one cycle after the pulse, as a retry or discard that does not match the processor-half transfer kind. A broken back-off path shows up one cycle after the retry, as a processor stall flag that is still high. The sweep covers every combination of kinds and FIFO flags on both halves, together with the split flag.

// File: rtl/bdl_pkg.sv
`timescale 1ns/1ps
package bdl_pkg;
    localparam int KIND_W = 2;

    typedef enum logic [KIND_W-1:0] {
        XK_NONE = 2'd0,
        XK_READ = 2'd1,
        XK_NPWR = 2'd2,
        XK_PWR  = 2'd3
    } xfer_kind_t;

    typedef enum logic [1:0] {
        LK_ARMED = 2'd0,
        LK_LOCK  = 2'd1,
        LK_RETRY = 2'd2,
        LK_HOLD  = 2'd3
    } lock_state_t;

    function automatic logic needs_far_bus(input xfer_kind_t k,
                                           input logic rd_empty,
                                           input logic wr_full);
        logic r;
        unique case (k)
            XK_NONE: r = 1'b0;
            XK_READ: r = rd_empty;
            XK_NPWR: r = 1'b1;
            XK_PWR:  r = wr_full;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/bdl_stall_detect.sv
`timescale 1ns/1ps
module bdl_stall_detect
    import bdl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [KIND_W-1:0] kind,
    input  logic              rd_empty,
    input  logic              wr_full,
    input  logic              backoff,
    output logic              stall_o
);
    xfer_kind_t kind_e;
    logic       need;

    always_comb begin
        kind_e = xfer_kind_t'(kind);
        need   = needs_far_bus(kind_e, rd_empty, wr_full);
    end

    // A side that has just been told to yield drops its flag for one cycle.
    always_ff @(posedge clk) begin
        if (rst) stall_o <= 1'b0;
        else     stall_o <= need & ~backoff;
    end
endmodule

// File: rtl/bdl_lock_ctrl.sv
`timescale 1ns/1ps
module bdl_lock_ctrl
    import bdl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_stall,
    input  logic              pci_stall,
    input  logic [KIND_W-1:0] cpu_kind,
    input  logic              cpu_split,
    output logic              lock_o,
    output logic              retry_o,
    output logic              discard_o,
    output logic              backoff_o
);
    lock_state_t state_q, state_d;
    logic        drop_q, drop_d;
    xfer_kind_t  ck;
    logic        both;

    always_comb begin
        ck   = xfer_kind_t'(cpu_kind);
        both = cpu_stall & pci_stall;
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LK_ARMED;
            drop_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            drop_q  <= drop_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        drop_d  = 1'b0;
        unique case (state_q)
            LK_ARMED: if (both) state_d = LK_LOCK;
            LK_LOCK: begin
                if (ck == XK_READ || ck == XK_NPWR) begin
                    state_d = LK_RETRY;
                    drop_d  = (ck == XK_READ) & cpu_split;
                end else begin
                    state_d = LK_HOLD;
                end
            end
            LK_RETRY: state_d = LK_HOLD;
            LK_HOLD:  if (!both) state_d = LK_ARMED;
        endcase
    end

    // Outputs
    always_comb begin
        lock_o    = 1'b0;
        retry_o   = 1'b0;
        discard_o = 1'b0;
        backoff_o = 1'b0;
        unique case (state_q)
            LK_ARMED: ;
            LK_LOCK:  lock_o = 1'b1;
            LK_RETRY: begin
                retry_o   = 1'b1;
                discard_o = drop_q;
                backoff_o = 1'b1;
            end
            LK_HOLD:  ;
        endcase
    end
endmodule

// File: rtl/bdl_bridge_lock.sv
`timescale 1ns/1ps
module bdl_bridge_lock
    import bdl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [KIND_W-1:0] cpu_kind,
    input  logic              cpu_rd_empty,
    input  logic              cpu_wr_full,
    input  logic              cpu_split,
    input  logic [KIND_W-1:0] pci_kind,
    input  logic              pci_rd_empty,
    input  logic              pci_wr_full,
    output logic              cpu_stall,
    output logic              pci_stall,
    output logic              lock_pulse,
    output logic              cpu_retry,
    output logic              cpu_discard
);
    logic cpu_backoff;

    bdl_stall_detect u_cpu_det (
        .clk(clk), .rst(rst), .kind(cpu_kind), .rd_empty(cpu_rd_empty),
        .wr_full(cpu_wr_full), .backoff(cpu_backoff), .stall_o(cpu_stall)
    );

    // The PCI half never yields, so its back-off is tied low.
    bdl_stall_detect u_pci_det (
        .clk(clk), .rst(rst), .kind(pci_kind), .rd_empty(pci_rd_empty),
        .wr_full(pci_wr_full), .backoff(1'b0), .stall_o(pci_stall)
    );

    bdl_lock_ctrl u_ctrl (
        .clk(clk), .rst(rst), .cpu_stall(cpu_stall), .pci_stall(pci_stall),
        .cpu_kind(cpu_kind), .cpu_split(cpu_split), .lock_o(lock_pulse),
        .retry_o(cpu_retry), .discard_o(cpu_discard), .backoff_o(cpu_backoff)
    );
endmodule

// File: rtl/bdl_checker.sv
`timescale 1ns/1ps
module bdl_checker (
    input logic clk,
    input logic rst,
    input logic cpu_stall,
    input logic pci_stall,
    input logic lock_pulse,
    input logic cpu_retry,
    input logic cpu_discard
);
    AST_LOCK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        lock_pulse |=> !lock_pulse);                                   // R4
    AST_LOCK_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
        lock_pulse |-> $past(cpu_stall && pci_stall));                 // R4
    AST_RETRY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        cpu_retry |=> !cpu_retry);                                     // R6
    AST_RETRY_AFTER_LOCK: assert property (@(posedge clk) disable iff (rst)
        cpu_retry |-> $past(lock_pulse));                              // R6
    AST_DISCARD_WITH_RETRY: assert property (@(posedge clk) disable iff (rst)
        cpu_discard |-> cpu_retry);                                    // R8
    AST_BACKOFF_LOW: assert property (@(posedge clk) disable iff (rst)
        cpu_retry |=> !cpu_stall);                                     // R9
endmodule

bind bdl_bridge_lock bdl_checker u_chk (
    .clk(clk), .rst(rst), .cpu_stall(cpu_stall), .pci_stall(pci_stall),
    .lock_pulse(lock_pulse), .cpu_retry(cpu_retry), .cpu_discard(cpu_discard)
);

// File: tb/sim_bdl_bridge_lock.sv
`timescale 1ns/1ps
module sim_bdl_bridge_lock;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cpu_kind = 2'd0, pci_kind = 2'd0;
    logic       cpu_rd_empty = 0, cpu_wr_full = 0, cpu_split = 0;
    logic       pci_rd_empty = 0, pci_wr_full = 0;
    logic       cpu_stall, pci_stall, lock_pulse, cpu_retry, cpu_discard;
    int         checks = 0, errors = 0, cycles = 0;

    always #2 clk = ~clk;

    bdl_bridge_lock u0 (
        .clk(clk), .rst(rst), .cpu_kind(cpu_kind), .cpu_rd_empty(cpu_rd_empty),
        .cpu_wr_full(cpu_wr_full), .cpu_split(cpu_split), .pci_kind(pci_kind),
        .pci_rd_empty(pci_rd_empty), .pci_wr_full(pci_wr_full),
        .cpu_stall(cpu_stall), .pci_stall(pci_stall), .lock_pulse(lock_pulse),
        .cpu_retry(cpu_retry), .cpu_discard(cpu_discard)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: act=%0d exp=%0d", cycles, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic exp_need(input logic [1:0] k, input logic re, input logic wf);
        return (k == 2'd1 && re) || (k == 2'd2) || (k == 2'd3 && wf);
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: act=%b exp=%b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cpu_kind = 0; pci_kind = 0;
        cpu_rd_empty = 0; cpu_wr_full = 0; cpu_split = 0;
        pci_rd_empty = 0; pci_wr_full = 0;
        tick(); tick();
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic check_idle(input string req);
        check({req, " cpu_stall"}, cpu_stall, 1'b0);
        check({req, " pci_stall"}, pci_stall, 1'b0);
        check({req, " lock"}, lock_pulse, 1'b0);
        check({req, " retry"}, cpu_retry, 1'b0);
        check({req, " discard"}, cpu_discard, 1'b0);
    endtask

    int pulses;

    initial begin
        do_reset();
        check_idle("R11 reset");

        // Exhaustive sweep: 4 kinds x 2 x 2 per side, split flag on cpu side
        for (int c = 0; c < 32; c++) begin
            for (int p = 0; p < 16; p++) begin
                logic es_c, es_p, both, do_retry, do_drop;
                do_reset();
                cpu_kind = c[1:0]; cpu_rd_empty = c[2]; cpu_wr_full = c[3]; cpu_split = c[4];
                pci_kind = p[1:0]; pci_rd_empty = p[2]; pci_wr_full = p[3];
                es_c = exp_need(cpu_kind, cpu_rd_empty, cpu_wr_full);
                es_p = exp_need(pci_kind, pci_rd_empty, pci_wr_full);
                both = es_c & es_p;
                do_retry = both && (cpu_kind == 2'd1 || cpu_kind == 2'd2);
                do_drop  = do_retry && cpu_kind == 2'd1 && cpu_split;
                tick(); // edge 1: stall flags
                check("R1_R2_R3 cpu_stall", cpu_stall, es_c);
                check("R1_R2_R3 pci_stall", pci_stall, es_p);
                check("R4 no early lock", lock_pulse, 1'b0);
                tick(); // edge 2: lock
                check("R4 lock", lock_pulse, both);
                tick(); // edge 3: resolution
                check("R4 pulse width", lock_pulse, 1'b0);
                check("R6_R7 retry", cpu_retry, do_retry);
                check("R8 discard", cpu_discard, do_drop);
                check("R10 pci_stall", pci_stall, es_p);
                tick(); // edge 4: back-off
                check("R6 retry width", cpu_retry, 1'b0);
                check("R9 cpu_stall", cpu_stall, do_retry ? 1'b0 : es_c);
                check("R10 pci_stall", pci_stall, es_p);
                check("R5 no refire", lock_pulse, 1'b0);
                tick();
                check("R5 no refire", lock_pulse, 1'b0);
            end
        end

        // R5: held posted-write deadlock fires once, re-arms after a stall drops
        do_reset();
        cpu_kind = 2'd3; cpu_wr_full = 1; pci_kind = 2'd2;
        pulses = 0;
        for (int i = 0; i < 12; i++) begin tick(); pulses += lock_pulse; end
        check("R5 single pulse while held", pulses == 1, 1'b1);
        check("R7 no retry on posted write", cpu_retry, 1'b0);
        @(negedge clk); pci_kind = 2'd0;
        for (int i = 0; i < 4; i++) begin tick(); pulses += lock_pulse; end
        check("R5 silent while dropped", pulses == 1, 1'b1);
        @(negedge clk); pci_kind = 2'd2;
        for (int i = 0; i < 6; i++) begin tick(); pulses += lock_pulse; end
        check("R5 re-armed", pulses == 2, 1'b1);

        // R11: reset in the middle of a resolution
        do_reset();
        cpu_kind = 2'd1; cpu_rd_empty = 1; cpu_split = 1; pci_kind = 2'd2;
        tick(); tick(); tick();
        check("R8 split discard", cpu_discard, 1'b1);
        @(negedge clk); rst = 1'b1;
        tick();
        check_idle("R11 mid reset");
        @(negedge clk); rst = 1'b0;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule